// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the 32-bit product into an accumulator held as a high word and a low word. A mode input selects one of two accumulate behaviours.

In saturating mode only the low word takes part in the sum. If the signed 32-bit sum leaves its range, the low word is clamped to the extreme value that matches the product's sign, and bit 0 of the high word is set as a sticky overflow flag. In wrapping mode the two words act as one 42-bit signed accumulator. The high word takes the product's sign extension and the carry out of the low-word addition, then it is sign-extended from its bit 9.

The block also returns two operand addresses, each advanced by 2 for every operation it accepts. The operands themselves come in directly on ports. A clear input and per-word load inputs set up the accumulator.

Top module: `sat_mac_unit`

## Requirements
- R1: The product is the signed 32-bit product of the two operands, each read as a two's-complement 16-bit value.
- R2: In saturating mode (sat_mode=1) with no overflow, acc_lo becomes acc_lo plus the product (32-bit signed) and acc_hi is left unchanged.
- R3: In saturating mode, overflow is when the product and acc_lo share a sign and the sum's sign differs from it. On an overflow with a non-negative product, acc_lo becomes 0x7FFFFFFF and acc_hi bit 0 is set.
- R4: On a saturating overflow with a negative product, acc_lo becomes 0x80000000 and acc_hi bit 0 is set.
- R5: Once acc_hi bit 0 is set, later saturating operations do not clear it.
- R6: In wrapping mode (sat_mode=0), acc_lo becomes the low 32 bits of acc_lo plus the product. acc_hi gains the carry out of that unsigned addition and loses 1 when the product is negative.
- R7: In wrapping mode the new acc_hi keeps its bits 9:0, and bits 31:10 become copies of bit 9, giving a 42-bit accumulator.
- R8: Each accepted operation sets ptr_a_out and ptr_b_out to ptr_a_in+2 and ptr_b_in+2 (modulo 2^32) as they were in the cycle of the strobe.
- R9: Results appear on the outputs at the clock edge that samples op_valid=1. With no strobe, clear or load, the outputs hold their values whatever the operand inputs do.
- R10: clr zeroes acc_hi and acc_lo, sticky bit included. It has priority over loads and operations, and an operation in the same cycle is dropped, so the pointers hold.
- R11: hi_load and lo_load write acc_hi and acc_lo from their value ports. Either load in the cycle of a strobe drops the operation: the unloaded word and the pointers hold.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_a | input | 16 | Signed operand A |
| op_b | input | 16 | Signed operand B |
| sat_mode | input | 1 | 1 = saturating accumulate, 0 = 42-bit wrapping accumulate |
| ptr_a_in | input | 32 | Address of operand A |
| ptr_b_in | input | 32 | Address of operand B |
| clr | input | 1 | Zero both accumulator words |
| hi_load | input | 1 | Write hi_load_val into the high word |
| hi_load_val | input | 32 | High-word load value |
| lo_load | input | 1 | Write lo_load_val into the low word |
| lo_load_val | input | 32 | Low-word load value |
| acc_hi | output | 32 | Accumulator high word (bit 0 is the sticky flag in saturating mode) |
| acc_lo | output | 32 | Accumulator low word |
| ptr_a_out | output | 32 | Operand A address advanced by 2 |
| ptr_b_out | output | 32 | Operand B address advanced by 2 |

## Verification
An operation strobe can arrive in the same cycle as a clear, or in the same cycle as a word load. Each pair must resolve to the clear or the load alone. The bench drives the strobe together with a clear and both loads, with operands that would change both words and both pointers. It expects zeros and unchanged pointers. It then pairs the strobe with a low-word load only, and expects the loaded low word, the old high word and unchanged pointers. Both outcomes are read at the ports on the following cycle.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int OPND_W  = 16;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int STEP    = 2;
  localparam int HI_KEEP = 10;

  typedef enum logic { MODE_WRAP = 1'b0, MODE_SAT = 1'b1 } acc_mode_e;
endpackage

// File: rtl/mac_mul.sv
`timescale 1ns/1ps
module mac_mul #(
  parameter int OPND_W = 16,
  parameter int WORD_W = 32
) (
  input  logic [OPND_W-1:0] a,
  input  logic [OPND_W-1:0] b,
  output logic [WORD_W-1:0] prod
);
  localparam int PROD_W = 2 * OPND_W;

  function automatic logic [WORD_W-1:0] smul(input logic [OPND_W-1:0] x, input logic [OPND_W-1:0] y);
    logic signed [PROD_W-1:0] p;
    p = $signed({{OPND_W{x[OPND_W-1]}}, x}) * $signed({{OPND_W{y[OPND_W-1]}}, y});
    return WORD_W'(p);
  endfunction

  assign prod = smul(a, b);
endmodule

// File: rtl/mac_sat_step.sv
`timescale 1ns/1ps
module mac_sat_step #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] prod,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] nhi,
  output logic [WORD_W-1:0] nlo,
  output logic              ovf
);
  localparam int MSB = WORD_W - 1;

  // returns {overflow, result word}
  function automatic logic [WORD_W:0] clamp_add(input logic [WORD_W-1:0] p, input logic [WORD_W-1:0] l);
    logic [WORD_W-1:0] s;
    logic              o;
    s = p + l;
    o = (p[MSB] == l[MSB]) && (s[MSB] != p[MSB]);
    if (o) s = p[MSB] ? {1'b1, {MSB{1'b0}}} : {1'b0, {MSB{1'b1}}};
    return {o, s};
  endfunction

  assign {ovf, nlo} = clamp_add(prod, lo);
  assign nhi = ovf ? (hi | WORD_W'(1)) : hi;
endmodule

// File: rtl/mac_wrap_step.sv
`timescale 1ns/1ps
module mac_wrap_step #(
  parameter int WORD_W  = 32,
  parameter int HI_KEEP = 10
) (
  input  logic [WORD_W-1:0] prod,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] nhi,
  output logic [WORD_W-1:0] nlo
);
  localparam int MSB   = WORD_W - 1;
  localparam int EXT_W = WORD_W - HI_KEEP;

  logic              carry;
  logic [WORD_W-1:0] hi_sum;

  function automatic logic [WORD_W-1:0] sext_hi(input logic [WORD_W-1:0] h);
    return {{EXT_W{h[HI_KEEP-1]}}, h[HI_KEEP-1:0]};
  endfunction

  assign {carry, nlo} = {1'b0, lo} + {1'b0, prod};
  assign hi_sum = hi + {WORD_W{prod[MSB]}} + WORD_W'(carry);
  assign nhi = sext_hi(hi_sum);
endmodule

// File: rtl/sat_mac_unit.sv
`timescale 1ns/1ps
module sat_mac_unit
  import mac_pkg::*;
#(
  parameter int P_OPND_W  = OPND_W,
  parameter int P_WORD_W  = WORD_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_STEP    = STEP,
  parameter int P_HI_KEEP = HI_KEEP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [P_OPND_W-1:0] op_a,
  input  logic [P_OPND_W-1:0] op_b,
  input  logic                sat_mode,
  input  logic [P_ADDR_W-1:0] ptr_a_in,
  input  logic [P_ADDR_W-1:0] ptr_b_in,
  input  logic                clr,
  input  logic                hi_load,
  input  logic [P_WORD_W-1:0] hi_load_val,
  input  logic                lo_load,
  input  logic [P_WORD_W-1:0] lo_load_val,
  output logic [P_WORD_W-1:0] acc_hi,
  output logic [P_WORD_W-1:0] acc_lo,
  output logic [P_ADDR_W-1:0] ptr_a_out,
  output logic [P_ADDR_W-1:0] ptr_b_out
);
  localparam int EXT_BITS = P_WORD_W - P_HI_KEEP + 1;
  localparam logic [P_WORD_W-1:0] POS_LIM = {1'b0, {(P_WORD_W-1){1'b1}}};
  localparam logic [P_WORD_W-1:0] NEG_LIM = {1'b1, {(P_WORD_W-1){1'b0}}};

  acc_mode_e         mode;
  logic              accept;
  logic              any_load;
  logic [P_WORD_W-1:0] prod;
  logic [P_WORD_W-1:0] s_hi, s_lo, w_hi, w_lo;
  logic              sat_ovf;

  assign mode     = acc_mode_e'(sat_mode);
  assign any_load = hi_load | lo_load;
  assign accept   = op_valid & ~clr & ~any_load;

  mac_mul #(.OPND_W(P_OPND_W), .WORD_W(P_WORD_W)) u_mul (
    .a(op_a), .b(op_b), .prod(prod));

  mac_sat_step #(.WORD_W(P_WORD_W)) u_sat (
    .prod(prod), .hi(acc_hi), .lo(acc_lo), .nhi(s_hi), .nlo(s_lo), .ovf(sat_ovf));

  mac_wrap_step #(.WORD_W(P_WORD_W), .HI_KEEP(P_HI_KEEP)) u_wrap (
    .prod(prod), .hi(acc_hi), .lo(acc_lo), .nhi(w_hi), .nlo(w_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi    <= '0;
      acc_lo    <= '0;
      ptr_a_out <= '0;
      ptr_b_out <= '0;
    end else if (clr) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (any_load) begin
      if (hi_load) acc_hi <= hi_load_val;
      if (lo_load) acc_lo <= lo_load_val;
    end else if (op_valid) begin
      if (mode == MODE_SAT) begin
        acc_hi <= s_hi;
        acc_lo <= s_lo;
      end else begin
        acc_hi <= w_hi;
        acc_lo <= w_lo;
      end
      ptr_a_out <= ptr_a_in + P_ADDR_W'(P_STEP);
      ptr_b_out <= ptr_b_in + P_ADDR_W'(P_STEP);
    end
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == '0) && (acc_lo == '0));

  assert_sat_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sat_mode && !sat_ovf) |=> $stable(acc_hi));

  // R3 and R4: clamp value and sticky flag
  assert_sat_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sat_mode && sat_ovf) |=> acc_hi[0] && ((acc_lo == POS_LIM) || (acc_lo == NEG_LIM)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sat_mode && acc_hi[0]) |=> acc_hi[0]);

  assert_wrap_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sat_mode) |=> (($countones(acc_hi[P_WORD_W-1:P_HI_KEEP-1]) == 0) ||
                               ($countones(acc_hi[P_WORD_W-1:P_HI_KEEP-1]) == EXT_BITS)));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ptr_a_out == $past(ptr_a_in) + P_ADDR_W'(P_STEP)) &&
               (ptr_b_out == $past(ptr_b_in) + P_ADDR_W'(P_STEP)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !clr && !any_load) |=> $stable(acc_hi) && $stable(acc_lo) &&
                                         $stable(ptr_a_out) && $stable(ptr_b_out));

  assert_load_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hi_load) |=> acc_hi == $past(hi_load_val));
endmodule

// File: tb/sim_sat_mac_unit.sv
`timescale 1ns/1ps
module sim_sat_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        sat_mode = 1'b0;
  logic [31:0] ptr_a_in = '0, ptr_b_in = '0;
  logic        clr = 1'b0, hi_load = 1'b0, lo_load = 1'b0;
  logic [31:0] hi_load_val = '0, lo_load_val = '0;
  logic [31:0] acc_hi, acc_lo, ptr_a_out, ptr_b_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sat_mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .sat_mode(sat_mode), .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .clr(clr),
    .hi_load(hi_load), .hi_load_val(hi_load_val), .lo_load(lo_load),
    .lo_load_val(lo_load_val), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out));

  // {a, b, sat, start hi, start lo, expected hi, expected lo}
  localparam logic [160:0] VEC [8] = '{
    {16'd3,    16'd4,    1'b1, 32'h0,        32'd10,       32'h0,        32'h16},        // R2
    {16'h7FFF, 16'h7FFF, 1'b1, 32'h0,        32'h7FFFFFFF, 32'h1,        32'h7FFFFFFF},  // R3
    {16'h8000, 16'h7FFF, 1'b1, 32'h0,        32'h80000000, 32'h1,        32'h80000000},  // R4
    {16'd2,    16'hFFFD, 1'b1, 32'h1,        32'd100,      32'h1,        32'h5E},        // R5
    {16'd1,    16'd1,    1'b0, 32'h0,        32'hFFFFFFFF, 32'h1,        32'h0},         // R6
    {16'hFFFF, 16'd1,    1'b0, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF},  // R6
    {16'd1,    16'd1,    1'b0, 32'h1FF,      32'hFFFFFFFF, 32'hFFFFFE00, 32'h0},         // R7
    {16'd2,    16'd3,    1'b0, 32'h12345678, 32'd5,        32'hFFFFFE78, 32'd11}         // R7
  };
  localparam string VREQ [8] = '{"R2", "R3", "R4", "R5", "R6", "R6", "R7", "R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_both(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    hi_load = 1'b1; lo_load = 1'b1; hi_load_val = h; lo_load_val = l;
    @(negedge clk);
    hi_load = 1'b0; lo_load = 1'b0;
  endtask

  task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; sat_mode = s; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // reference: 64-bit arithmetic on a 42-bit view / signed range test
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic s,
                       inout logic [31:0] hi, inout logic [31:0] lo);
    longint p;
    longint sm;
    logic signed [63:0] acc;
    p = longint'($signed(a)) * longint'($signed(b));
    if (s) begin
      sm = longint'($signed(lo)) + p;
      if (sm > 64'sd2147483647) begin lo = 32'h7FFFFFFF; hi[0] = 1'b1; end
      else if (sm < -64'sd2147483648) begin lo = 32'h80000000; hi[0] = 1'b1; end
      else lo = sm[31:0];
    end else begin
      acc = {{22{hi[9]}}, hi[9:0], lo};
      acc = acc + p;
      lo = acc[31:0];
      hi = {{22{acc[41]}}, acc[41:32]};
    end
  endtask

  initial begin
    logic [31:0] eh, el;
    ptr_a_in = 32'h100; ptr_b_in = 32'h200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 hi", acc_hi, 32'h0);
    check("R12 lo", acc_lo, 32'h0);
    check("R12 pa", ptr_a_out, 32'h0);
    check("R12 pb", ptr_b_out, 32'h0);

    // R1: product alone lands in the low word
    load_both(32'h0, 32'h0);
    do_op(16'hFFF9, 16'd9, 1'b1);
    check("R1 lo", acc_lo, 32'hFFFFFFC1);
    check("R1 hi", acc_hi, 32'h0);

    for (int i = 0; i < 8; i++) begin
      load_both(VEC[i][127:96], VEC[i][95:64]);
      do_op(VEC[i][160:145], VEC[i][144:129], VEC[i][128]);
      check({VREQ[i], " hi"}, acc_hi, VEC[i][63:32]);
      check({VREQ[i], " lo"}, acc_lo, VEC[i][31:0]);
    end

    // R8: pointer step, with wrap at the top of the address space
    ptr_a_in = 32'h1000; ptr_b_in = 32'hFFFFFFFF;
    do_op(16'd1, 16'd1, 1'b0);
    check("R8 pa", ptr_a_out, 32'h1002);
    check("R8 pb", ptr_b_out, 32'h1);

    // R9: operand activity without strobe changes nothing
    eh = acc_hi; el = acc_lo;
    @(negedge clk); op_a = 16'h7FFF; op_b = 16'h7FFF; sat_mode = 1'b1; ptr_a_in = 32'h5;
    repeat (3) @(negedge clk);
    check("R9 hi", acc_hi, eh);
    check("R9 lo", acc_lo, el);
    check("R9 pa", ptr_a_out, 32'h1002);

    // R10: clear together with strobe and both loads
    load_both(32'h1, 32'h1234);
    @(negedge clk);
    clr = 1'b1; op_valid = 1'b1; hi_load = 1'b1; lo_load = 1'b1;
    hi_load_val = 32'hAAAA; lo_load_val = 32'h5555;
    op_a = 16'd7; op_b = 16'd7; ptr_a_in = 32'h40; ptr_b_in = 32'h80;
    @(negedge clk);
    clr = 1'b0; op_valid = 1'b0; hi_load = 1'b0; lo_load = 1'b0;
    check("R10 hi", acc_hi, 32'h0);
    check("R10 lo", acc_lo, 32'h0);
    check("R10 pa", ptr_a_out, 32'h1002);

    // R11: low load together with strobe
    load_both(32'h33, 32'h44);
    @(negedge clk);
    lo_load = 1'b1; lo_load_val = 32'h99; op_valid = 1'b1; sat_mode = 1'b0;
    @(negedge clk);
    lo_load = 1'b0; op_valid = 1'b0;
    check("R11 lo", acc_lo, 32'h99);
    check("R11 hi", acc_hi, 32'h33);
    check("R11 pb", ptr_b_out, 32'h1);

    // R7/R6: long wrapping run past the 42-bit range
    load_both(32'h0, 32'h0);
    eh = 32'h0; el = 32'h0;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      if (($urandom % 10) != 0) begin a = 16'h8000; b = 16'h8000; end
      else begin a = 16'($urandom); b = 16'($urandom); end
      do_op(a, b, 1'b0);
      model(a, b, 1'b0, eh, el);
      check("R7 run hi", acc_hi, eh);
      check("R6 run lo", acc_lo, el);
    end

    // mixed modes, large operands provoke overflow both ways (R3 R4 R5)
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a, b;
      logic s;
      s = ($urandom % 4) != 0;
      a = (($urandom % 2) != 0) ? 16'h7FFF : 16'($urandom);
      b = (($urandom % 2) != 0) ? 16'h8000 : 16'($urandom);
      if (($urandom % 2) != 0) b = 16'h7FFF;
      do_op(a, b, s);
      model(a, b, s, eh, el);
      check("R3 mix hi", acc_hi, eh);
      check("R4 mix lo", acc_lo, el);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule